// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits on the host side of an asynchronous, page-organised 32-bit read-only memory with a 24-bit word address. It takes single-word read requests on a valid/ready handshake, drives the memory's chip-select, output-enable and address pins, and waits a counted number of clock cycles before it samples the memory's data pins. It returns each word with a one-cycle response pulse. Only one request can be in flight at a time.

A page is eight words. The low three address bits pick the word inside a page and the upper 21 bits pick the page. The controller remembers which page is open. A read that stays in that page waits only the short in-page access time. A read to another page, or the first read after the memory was enabled, waits the full random access time. On that first read the wait is the larger of the address path and the output-enable path. All access times are parameters given in nanoseconds, and each is rounded up to whole clock cycles.

If no request arrives for a set number of cycles, the controller raises chip select to put the memory in standby and forgets the open page. It then counts the output float time before it reports the data bus free.

Top module: `pmrom_reader`

## Requirements
- R1: While reset is held and directly after it, chip select and output enable are high (inactive), the response pulse is low, request-ready is high and the bus-free flag is high.
- R2: A read accepted while the memory is in standby samples data after max(ceil(T_RAND_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS)) clock cycles, counted from the accepting clock edge to the capturing edge. With the defaults this is 12 cycles.
- R3: A read whose address bits [23:3] match the open page samples data after ceil(T_PAGE_NS/CLK_PERIOD_NS) cycles. With the defaults this is 4 cycles.
- R4: A read to a different page, while the memory stays enabled, waits the full random access count of R2.
- R5: From acceptance until data capture, chip select and output enable stay low (active) and the address pins hold the accepted address.
- R6: Request-ready is low from the accepting edge until the response. The response pulse lasts exactly one cycle.
- R7: When no request arrives, chip select and output enable go high IDLE_CYCLES cycles after the response pulse (16 by default). The open page is then forgotten, so the next read to that same page waits the full random access count.
- R8: After chip select goes high, the bus-free flag rises ceil(T_FLOAT_NS/CLK_PERIOD_NS) cycles later (3 by default). Request-ready stays low in that interval, and the bus-free flag is low whenever chip select is low.
- R9: The returned word equals the value on the memory's data pins at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | 24 | Word address of the request |
| rsp_valid_o | output | 1 | One-cycle pulse: read data valid |
| rsp_data_o | output | 32 | Read data |
| rom_ce_n_o | output | 1 | Memory chip select, active low |
| rom_oe_n_o | output | 1 | Memory output enable, active low |
| rom_addr_o | output | 24 | Memory address pins |
| rom_data_i | input | 32 | Memory data pins |
| rom_bus_idle_o | output | 1 | Data bus has floated and is free |

## Verification
The hardest case to reach is the one where a page was left open, the standby timeout has closed it, and a read then targets that same page. It must take the long path, even though its page bits match the stored ones. The bench first opens the page with in-page reads, then stays silent past the timeout while it counts the cycles to chip-select release and to bus-free. It then reissues an address in the old page. The memory model in the bench returns a poison pattern unless every timing rule has been met, so a wait that is too short shows up as a data mismatch as well as a latency mismatch.

// File: rtl/pmrom_pkg.sv
package pmrom_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_OPEN  = 2'd2,
        ST_FLOAT = 2'd3
    } rd_state_e;

    function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmrom_wait_timer.sv
module pmrom_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pmrom_idle_timer.sv
module pmrom_idle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);

    localparam int unsigned IW = $clog2(LIMIT + 1);
    localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pmrom_page_tracker.sv
module pmrom_page_tracker #(
    parameter int unsigned PAGE_W = 21
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              clr_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0] cmp_i,
    output logic              hit_o
);

    typedef struct packed {
        logic              vld;
        logic [PAGE_W-1:0] page;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clr_i) begin
            trk_d.vld = 1'b0;
        end else if (load_i) begin
            trk_d.vld  = 1'b1;
            trk_d.page = page_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    assign hit_o = trk_q.vld && (trk_q.page == cmp_i);

endmodule

// File: rtl/pmrom_reader.sv
module pmrom_reader
    import pmrom_pkg::*;
#(
    parameter int unsigned ADDR_W        = 24,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned WORD_SEL_W    = 3,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_RAND_NS     = 90,
    parameter int unsigned T_PAGE_NS     = 30,
    parameter int unsigned T_OE_NS       = 30,
    parameter int unsigned T_FLOAT_NS    = 20,
    parameter int unsigned IDLE_CYCLES   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rom_ce_n_o,
    output logic              rom_oe_n_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              rom_bus_idle_o
);

    localparam int unsigned PAGE_W    = ADDR_W - WORD_SEL_W;
    localparam int unsigned RAND_CYC  = max_u(cyc_ceil(T_RAND_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned PAGE_CYC  = max_u(cyc_ceil(T_PAGE_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned OE_CYC    = max_u(cyc_ceil(T_OE_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned FLOAT_CYC = max_u(cyc_ceil(T_FLOAT_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned FIRST_CYC = max_u(RAND_CYC, OE_CYC);
    localparam int unsigned CNT_W     = $clog2(max_u(max_u(FIRST_CYC, PAGE_CYC), FLOAT_CYC) + 1);
    localparam logic [CNT_W-1:0] LD_FIRST = CNT_W'(FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RAND  = CNT_W'(FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PAGE  = CNT_W'(PAGE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_FLOAT = CNT_W'(FLOAT_CYC - 1);

    typedef struct packed {
        rd_state_e         st;
        logic              ce_n;
        logic              oe_n;
        logic [ADDR_W-1:0] addr;
        logic              rsp_vld;
        logic [DATA_W-1:0] rsp_data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             accept;
    logic             wait_load;
    logic [CNT_W-1:0] wait_val;
    logic             wait_exp;
    logic             idle_run;
    logic             idle_clr;
    logic             idle_exp;
    logic             page_load;
    logic             page_clr;
    logic             page_hit;

    assign req_ready_o = (ctrl_q.st == ST_OFF) || (ctrl_q.st == ST_OPEN);
    assign accept      = req_valid_i && req_ready_o;
    assign idle_run    = (ctrl_q.st == ST_OPEN) && !accept;
    assign idle_clr    = (ctrl_q.st != ST_OPEN) || accept;

    pmrom_wait_timer #(.CNT_W(CNT_W)) u_wait (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (wait_load),
        .load_val_i (wait_val),
        .expired_o  (wait_exp)
    );

    pmrom_idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (idle_run),
        .clr_i     (idle_clr),
        .expired_o (idle_exp)
    );

    pmrom_page_tracker #(.PAGE_W(PAGE_W)) u_page (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (page_load),
        .clr_i  (page_clr),
        .page_i (req_addr_i[ADDR_W-1:WORD_SEL_W]),
        .cmp_i  (req_addr_i[ADDR_W-1:WORD_SEL_W]),
        .hit_o  (page_hit)
    );

    always_comb begin
        ctrl_d         = ctrl_q;
        ctrl_d.rsp_vld = 1'b0;
        wait_load      = 1'b0;
        wait_val       = '0;
        page_load      = 1'b0;
        page_clr       = 1'b0;
        unique case (ctrl_q.st)
            ST_OFF: begin
                if (accept) begin
                    ctrl_d.ce_n = 1'b0;
                    ctrl_d.oe_n = 1'b0;
                    ctrl_d.addr = req_addr_i;
                    ctrl_d.st   = ST_WAIT;
                    wait_load   = 1'b1;
                    wait_val    = LD_FIRST;
                    page_load   = 1'b1;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    ctrl_d.addr = req_addr_i;
                    ctrl_d.st   = ST_WAIT;
                    wait_load   = 1'b1;
                    wait_val    = page_hit ? LD_PAGE : LD_RAND;
                    page_load   = 1'b1;
                end else if (idle_exp) begin
                    ctrl_d.ce_n = 1'b1;
                    ctrl_d.oe_n = 1'b1;
                    ctrl_d.st   = ST_FLOAT;
                    wait_load   = 1'b1;
                    wait_val    = LD_FLOAT;
                    page_clr    = 1'b1;
                end
            end
            ST_WAIT: begin
                if (wait_exp) begin
                    ctrl_d.rsp_vld  = 1'b1;
                    ctrl_d.rsp_data = rom_data_i;
                    ctrl_d.st       = ST_OPEN;
                end
            end
            ST_FLOAT: begin
                if (wait_exp) begin
                    ctrl_d.st = ST_OFF;
                end
            end
            default: ctrl_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q      <= '0;
            ctrl_q.st   <= ST_OFF;
            ctrl_q.ce_n <= 1'b1;
            ctrl_q.oe_n <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rsp_valid_o    = ctrl_q.rsp_vld;
    assign rsp_data_o     = ctrl_q.rsp_data;
    assign rom_ce_n_o     = ctrl_q.ce_n;
    assign rom_oe_n_o     = ctrl_q.oe_n;
    assign rom_addr_o     = ctrl_q.addr;
    assign rom_bus_idle_o = (ctrl_q.st == ST_OFF);

    // R5
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.st == ST_WAIT && !wait_exp) |=> $stable(rom_addr_o));

    // R5
    enables_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.st == ST_WAIT) |-> (!rom_ce_n_o && !rom_oe_n_o));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |=> !rsp_valid_o);

    // R6
    one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R7
    page_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rom_ce_n_o |-> !page_hit);

    // R8
    bus_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rom_bus_idle_o |-> rom_ce_n_o);

endmodule

// File: tb/pmrom_reader_tb_top.sv
module pmrom_reader_tb_top;

    localparam int CLK_P   = 8;
    localparam int T_RAND  = 90;
    localparam int T_PAGE  = 30;
    localparam int T_OE    = 30;
    localparam int T_FLOAT = 20;
    localparam int IDLE    = 16;
    localparam int LAT_RND = ((T_RAND + CLK_P - 1) / CLK_P > (T_OE + CLK_P - 1) / CLK_P)
                             ? (T_RAND + CLK_P - 1) / CLK_P : (T_OE + CLK_P - 1) / CLK_P;
    localparam int LAT_PG  = (T_PAGE + CLK_P - 1) / CLK_P;
    localparam int LAT_FLT = (T_FLOAT + CLK_P - 1) / CLK_P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        ce_n, oe_n, bus_idle;
    logic [23:0] rom_addr;
    logic [31:0] rom_q = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [23:0] addr;
        int          lat;
        int          acc;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    pmrom_reader dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_valid_i    (req_valid),
        .req_ready_o    (req_ready),
        .req_addr_i     (req_addr),
        .rsp_valid_o    (rsp_valid),
        .rsp_data_o     (rsp_data),
        .rom_ce_n_o     (ce_n),
        .rom_oe_n_o     (oe_n),
        .rom_addr_o     (rom_addr),
        .rom_data_i     (rom_q),
        .rom_bus_idle_o (bus_idle)
    );

    initial forever #(CLK_P / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rom_fn(input logic [23:0] a);
        return {a[11:0] ^ 12'h3C5, a[23:12] ^ 12'hA96, a[7:0]};
    endfunction

    // memory model: poison unless every access time has elapsed
    longint t_page = 0, t_word = 0, t_ce = 0, t_oe = 0;
    always @(rom_addr[23:3]) t_page = $time;
    always @(rom_addr)       t_word = $time;
    always @(negedge ce_n)   t_ce   = $time;
    always @(negedge oe_n)   t_oe   = $time;
    initial forever begin
        #1;
        if (!ce_n && !oe_n && ($time - t_ce >= T_RAND) && ($time - t_oe >= T_OE) &&
            ($time - t_page >= T_RAND) && ($time - t_word >= T_PAGE))
            rom_q = rom_fn(rom_addr);
        else
            rom_q = 32'hDEAD_BEEF ^ {8'h00, rom_addr};
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items as responses appear
    bit prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp) chk(!rsp_valid, "R6 pulse width", longint'(rsp_valid), 0);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_data == rom_fn(e.addr), "R9 data", rsp_data, rom_fn(e.addr));
                    chk((cyc - e.acc) == e.lat, e.req, cyc - e.acc, e.lat);
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    task automatic do_read(input logic [23:0] a, input int lat, input string req);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        e.addr = a; e.lat = lat; e.acc = cyc; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R6 ready low while busy", longint'(req_ready), 0);
        chk(!ce_n && !oe_n, "R5 enables active", longint'({ce_n, oe_n}), 0);
        chk(rom_addr == a, "R5 address driven", rom_addr, a);
        chk(!bus_idle, "R8 bus busy while enabled", longint'(bus_idle), 0);
        while (!rsp_valid) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(ce_n && oe_n, "R1 enables idle in reset", longint'({ce_n, oe_n}), 3);
        chk(!rsp_valid, "R1 no response in reset", longint'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", longint'(req_ready), 1);
        chk(bus_idle, "R1 bus free after reset", longint'(bus_idle), 1);

        do_read(24'h000100, LAT_RND, "R2 first read latency");
        do_read(24'h000101, LAT_PG,  "R3 page hit latency");
        do_read(24'h000107, LAT_PG,  "R3 page hit last word");
        do_read(24'h000108, LAT_RND, "R4 next page latency");
        do_read(24'h000108, LAT_PG,  "R3 same word again");
        do_read(24'hFFFFFF, LAT_RND, "R4 far page latency");
        do_read(24'hFFFFF8, LAT_PG,  "R3 top page hit");
        repeat (10) @(negedge clk);
        do_read(24'hFFFFF9, LAT_PG,  "R7 page kept before timeout");

        begin
            int n = 0;
            while (!ce_n && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n == IDLE, "R7 idle timeout", n, IDLE);
            chk(oe_n, "R7 output enable released", longint'(oe_n), 1);
        end
        begin
            int m = 0;
            while (!bus_idle && m < 100) begin
                chk(!req_ready, "R8 ready low while floating", longint'(req_ready), 0);
                @(negedge clk);
                m++;
            end
            chk(m == LAT_FLT, "R8 float wait", m, LAT_FLT);
        end
        do_read(24'hFFFFFA, LAT_RND, "R7 reopen after standby");
        do_read(24'h00ABC3, LAT_RND, "R4 new page");
        do_read(24'h00ABC0, LAT_PG,  "R3 page hit word 0");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * CLK_P);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule